// File: doc/BRIEF.md
# Stalling Two-Phase EEPROM Write Controller

This block sits between a microprocessor bus and a byte-wide electrically erasable memory that needs a long write time. When the CPU writes to the memory's decoded address, the controller pulls the CPU ready line low at once. It keeps ready low until programming is over, so the CPU holds its bus cycle open and runs no other code. During that time the controller drives the programming-voltage enable and the memory strobes from a copy of the address and data taken when the write began.

A normal byte write has two timed pulses. The first pulse clears the byte by writing all ones. The second pulse writes the CPU's data. A one-cycle recovery slot separates the two pulses. A second decoded select starts a whole-device erase, which is a single pulse with the erase strobe raised. A mode input makes a write skip the clearing pulse, for use after a whole-device erase. Reads reach the memory with no wait states. The pulse length is derived from a clock-frequency parameter and a pulse-duration parameter, so a bench can shorten it.

Top module: `eeprom_wait_ctl`

## Requirements
- R1: A programming sequence starts only in a cycle where `cpu_wr` is high together with `mem_sel` or `ers_sel`. A write with neither select active, or a select held without `cpu_wr`, leaves `cpu_ready` high and `vpp_en` low.
- R2: `cpu_ready` drops in the same cycle as the starting write and stays low until the last pulse and any recovery slot are over. A full byte write holds it low for 2*P+2 cycles, where P is the pulse length in clock cycles (P = CLK_HZ/1000*PULSE_US/1000).
- R3: Every pulse holds `vpp_en` high for exactly P consecutive cycles. In a two-phase write, `vpp_en` is low for exactly one cycle between the two pulses.
- R4: During the clearing pulse `mem_we` is high and `mem_wdata` is all ones. During the data pulse `mem_we` is high and `mem_wdata` equals the CPU data captured at the start.
- R5: `mem_addr` and `mem_wdata` are taken from the CPU bus in the starting cycle. Later changes on `cpu_addr` and `cpu_wdata` do not reach the memory pins until the sequence ends.
- R6: `mem_oe` is low in every cycle in which `vpp_en` is high.
- R7: A write through `ers_sel` (with ERASE_EN=1) runs one pulse of P cycles with `mem_erase` high and `mem_we` low. `cpu_ready` is low for P+1 cycles. `ers_sel` takes priority over `mem_sel`.
- R8: If `skip_clear` is high when a write starts, only the data pulse runs. `cpu_ready` is low for P+1 cycles and no cycle carries all-ones data.
- R9: A read (`mem_sel` and `cpu_rd` high, `cpu_wr` low) keeps `cpu_ready` high, drives `mem_oe` high, and passes `mem_rdata` to `cpu_rdata` unchanged.
- R10: When a sequence ends with `cpu_wr` still high, no new sequence starts until `cpu_wr` has been seen low. During that wait `cpu_ready` stays high and `vpp_en` stays low.
- R11: A synchronous reset, including one in the middle of a sequence, returns the block to idle on the next clock edge: `vpp_en`, `mem_we` and `mem_erase` are low, and `cpu_ready` is high while no write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Read data returned to the CPU |
| cpu_wr | input | 1 | CPU write strobe, active high |
| cpu_rd | input | 1 | CPU read strobe, active high |
| mem_sel | input | 1 | Decoded byte-access select for the memory |
| ers_sel | input | 1 | Decoded whole-device erase select |
| skip_clear | input | 1 | Run the data pulse only |
| cpu_ready | output | 1 | CPU ready; low stalls the bus cycle |
| mem_addr | output | AW | Memory address pins |
| mem_wdata | output | DW | Memory data pins, write direction |
| mem_rdata | input | DW | Memory data pins, read direction |
| mem_ce | output | 1 | Memory chip enable, active high |
| mem_oe | output | 1 | Memory output enable, active high |
| mem_we | output | 1 | Byte programming strobe, active high |
| mem_erase | output | 1 | Whole-device erase strobe, active high |
| vpp_en | output | 1 | Programming-voltage switch enable |

## Verification
The assertions assume the CPU behaves like a bus master held by ready. Once a write has stalled, the CPU keeps its strobe high until ready returns, and it never raises read and write in the same cycle. The bench follows this rule. It changes the CPU address and data during the stall only to check that the captured values are used. It lowers the write strobe only after ready is high again or together with a reset. Selects and the skip mode change only between transactions.

// File: rtl/eewc_pkg.sv
package eewc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CLEAR   = 3'd1,
      ST_GAP     = 3'd2,
      ST_WRITE   = 3'd3,
      ST_ERASE   = 3'd4,
      ST_RELEASE = 3'd5
   } eewc_state_e;

   function automatic logic st_is_quiet(eewc_state_e s);
      return (s == ST_IDLE) || (s == ST_RELEASE);
   endfunction

   function automatic logic st_is_pulse(eewc_state_e s);
      return (s == ST_CLEAR) || (s == ST_WRITE) || (s == ST_ERASE);
   endfunction

endpackage

// File: rtl/eewc_pulse_timer.sv
module eewc_pulse_timer #(
   parameter int PULSE_CYC = 8,
   parameter int CNT_W     = $clog2(PULSE_CYC + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic expired
);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/eewc_seq.sv
module eewc_seq
   import eewc_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        req,
   input  logic        req_erase,
   input  logic        skip_clear,
   input  logic        wr_level,
   input  logic        expired,
   output eewc_state_e state,
   output logic        start,
   output logic        load
);
   eewc_state_e state_q, state_d;

   assign start = (state_q == ST_IDLE) && req;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               load = 1'b1;
               if (req_erase)       state_d = ST_ERASE;
               else if (skip_clear) state_d = ST_WRITE;
               else                 state_d = ST_CLEAR;
            end
         end
         ST_CLEAR: begin
            if (expired) state_d = ST_GAP;
         end
         ST_GAP: begin
            load    = 1'b1;
            state_d = ST_WRITE;
         end
         ST_WRITE, ST_ERASE: begin
            if (expired) state_d = ST_RELEASE;
         end
         ST_RELEASE: begin
            if (!wr_level) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/eewc_hold.sv
module eewc_hold #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          capture,
   input  logic          use_held,
   input  logic          force_ones,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   output logic [AW-1:0] pin_addr,
   output logic [DW-1:0] pin_data
);
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (capture) begin
         addr_q <= bus_addr;
         data_q <= bus_data;
      end
   end

   assign pin_addr = use_held ? addr_q : bus_addr;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign pin_data[b] = force_ones | data_q[b];
   end
endmodule

// File: rtl/eeprom_wait_ctl.sv
module eeprom_wait_ctl
   import eewc_pkg::*;
#(
   parameter int AW       = 11,
   parameter int DW       = 8,
   parameter int CLK_HZ   = 50_000_000,
   parameter int PULSE_US = 10_000,
   parameter bit ERASE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   input  logic          cpu_wr,
   input  logic          cpu_rd,
   input  logic          mem_sel,
   input  logic          ers_sel,
   input  logic          skip_clear,
   output logic          cpu_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_ce,
   output logic          mem_oe,
   output logic          mem_we,
   output logic          mem_erase,
   output logic          vpp_en
);
   localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
   localparam int CNT_W     = $clog2(PULSE_CYC + 1);

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("eeprom_wait_ctl: AW and DW must be positive");
   end
   if (PULSE_CYC < 2) begin : g_bad_pulse
      $error("eeprom_wait_ctl: pulse must last at least two clock cycles");
   end

   logic        req, req_erase, start, load, expired;
   logic        quiet, in_pulse;
   eewc_state_e state;

   if (ERASE_EN) begin : g_erase
      assign req_erase = ers_sel;
      assign req       = cpu_wr && (mem_sel || ers_sel);
   end else begin : g_no_erase
      assign req_erase = 1'b0;
      assign req       = cpu_wr && (mem_sel || ers_sel);
   end

   eewc_seq u_seq (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .req_erase  (req_erase),
      .skip_clear (skip_clear),
      .wr_level   (cpu_wr),
      .expired    (expired),
      .state      (state),
      .start      (start),
      .load       (load)
   );

   eewc_pulse_timer #(
      .PULSE_CYC (PULSE_CYC),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .expired (expired)
   );

   assign quiet    = st_is_quiet(state);
   assign in_pulse = st_is_pulse(state);

   eewc_hold #(
      .AW (AW),
      .DW (DW)
   ) u_hold (
      .clk        (clk),
      .rst        (rst),
      .capture    (start),
      .use_held   (!quiet),
      .force_ones (state == ST_CLEAR),
      .bus_addr   (cpu_addr),
      .bus_data   (cpu_wdata),
      .pin_addr   (mem_addr),
      .pin_data   (mem_wdata)
   );

   assign cpu_ready = quiet && !start;
   assign vpp_en    = in_pulse;
   assign mem_we    = (state == ST_CLEAR) || (state == ST_WRITE);
   assign mem_erase = (state == ST_ERASE);
   assign mem_ce    = quiet ? mem_sel : 1'b1;
   assign mem_oe    = quiet && mem_sel && cpu_rd && !cpu_wr;
   assign cpu_rdata = mem_rdata;
endmodule

// File: rtl/eeprom_wait_ctl_chk.sv
module eeprom_wait_ctl_chk #(
   parameter int AW       = 11,
   parameter int DW       = 8,
   parameter int CLK_HZ   = 50_000_000,
   parameter int PULSE_US = 10_000
) (
   input logic          clk,
   input logic          rst,
   input logic          cpu_wr,
   input logic          mem_sel,
   input logic          ers_sel,
   input logic          cpu_ready,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_oe,
   input logic          mem_we,
   input logic          mem_erase,
   input logic          vpp_en
);
   localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
   localparam int RUN_W     = $clog2(PULSE_CYC + 2);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst)         run_q <= '0;
      else if (vpp_en) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   AST_NO_START_WO_SEL: assert property (@(posedge clk) disable iff (rst)
      (cpu_ready && !(cpu_wr && (mem_sel || ers_sel))) |=> !vpp_en); // R1
   AST_STALL_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
      vpp_en |-> !cpu_ready); // R2
   AST_PULSE_FROM_STALL: assert property (@(posedge clk) disable iff (rst)
      $rose(vpp_en) |-> !$past(cpu_ready)); // R2
   AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (rst)
      (!vpp_en && run_q != '0) |-> (run_q == RUN_W'(PULSE_CYC))); // R3
   AST_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
      vpp_en |-> (run_q < RUN_W'(PULSE_CYC))); // R3
   AST_PINS_STABLE: assert property (@(posedge clk) disable iff (rst)
      (vpp_en && $past(vpp_en)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R5
   AST_OE_OFF_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
      vpp_en |-> !mem_oe); // R6
   AST_ERASE_EXCL: assert property (@(posedge clk) disable iff (rst)
      mem_erase |-> (vpp_en && !mem_we)); // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!vpp_en && !mem_we && !mem_erase)); // R11
endmodule

bind eeprom_wait_ctl eeprom_wait_ctl_chk #(
   .AW       (AW),
   .DW       (DW),
   .CLK_HZ   (CLK_HZ),
   .PULSE_US (PULSE_US)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cpu_wr    (cpu_wr),
   .mem_sel   (mem_sel),
   .ers_sel   (ers_sel),
   .cpu_ready (cpu_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_oe    (mem_oe),
   .mem_we    (mem_we),
   .mem_erase (mem_erase),
   .vpp_en    (vpp_en)
);

// File: tb/eeprom_wait_ctl_tb_top.sv
module eeprom_wait_ctl_tb_top;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int CLK_HZ = 1_000_000;
   localparam int PULSE_US = 8;
   localparam int P = (CLK_HZ / 1000) * PULSE_US / 1000;

   typedef struct packed {
      logic          sel;
      logic          ers;
      logic          skip;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 11'h123, 8'h5A},
      '{1'b1, 1'b0, 1'b0, 11'h7FF, 8'h00},
      '{1'b1, 1'b0, 1'b1, 11'h001, 8'hC3},
      '{1'b0, 1'b0, 1'b0, 11'h200, 8'h11},
      '{1'b0, 1'b1, 1'b0, 11'h000, 8'h00},
      '{1'b1, 1'b1, 1'b0, 11'h055, 8'h0F}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic          mem_sel = 1'b0, ers_sel = 1'b0, skip_clear = 1'b0;
   logic          cpu_ready;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ce, mem_oe, mem_we, mem_erase, vpp_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   eeprom_wait_ctl #(
      .AW (AW), .DW (DW), .CLK_HZ (CLK_HZ), .PULSE_US (PULSE_US), .ERASE_EN (1'b1)
   ) dut_i (
      .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata), .cpu_wr (cpu_wr), .cpu_rd (cpu_rd),
      .mem_sel (mem_sel), .ers_sel (ers_sel), .skip_clear (skip_clear),
      .cpu_ready (cpu_ready), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata), .mem_ce (mem_ce), .mem_oe (mem_oe),
      .mem_we (mem_we), .mem_erase (mem_erase), .vpp_en (vpp_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic run_vec(input vec_t v);
      int lows = 0, vpps = 0, clr = 0, dat = 0, ers = 0, bad = 0;
      int exp_low, exp_clr, exp_dat, exp_ers;
      bit go, gap_ok;
      gap_ok = 1'b1;
      go = v.sel || v.ers;
      exp_ers = v.ers ? P : 0;
      exp_dat = (go && !v.ers) ? P : 0;
      exp_clr = (go && !v.ers && !v.skip) ? P : 0;
      exp_low = !go ? 0 : ((v.ers || v.skip) ? P + 1 : 2 * P + 2);
      @(negedge clk);
      cpu_addr = v.addr; cpu_wdata = v.data;
      mem_sel = v.sel; ers_sel = v.ers; skip_clear = v.skip; cpu_wr = 1'b1;
      #1;
      for (int k = 0; k < 4 * P; k++) begin
         if (cpu_ready) break;
         lows++;
         if (vpp_en) begin
            vpps++;
            if (mem_oe || mem_addr != v.addr) bad++;
            if (mem_erase) ers++;
            else if (mem_we && mem_wdata == '1) clr++;
            else if (mem_we && mem_wdata == v.data) dat++;
         end else if (k > 0 && k != P + 1) begin
            gap_ok = 1'b0;
         end
         @(negedge clk); #1;
         cpu_addr = ~v.addr; cpu_wdata = ~v.data;
      end
      chk(lows == exp_low, "R2 ready-low cycles", lows, exp_low);
      chk(vpps == exp_clr + exp_dat + exp_ers, "R3 vpp cycles", vpps, exp_clr + exp_dat + exp_ers);
      chk(gap_ok, "R3 single recovery slot", gap_ok, 1);
      chk(clr == exp_clr, "R4 clear-phase ones cycles", clr, exp_clr);
      chk(dat == exp_dat, "R4 data-phase cycles", dat, exp_dat);
      chk(bad == 0, "R5/R6 held address and oe off", bad, 0);
      if (v.ers) chk(ers == P, "R7 erase pulse cycles", ers, P);
      if (v.skip) chk(clr == 0, "R8 no clear phase", clr, 0);
      if (!go) chk(lows == 0, "R1 no select no stall", lows, 0);
      for (int k = 0; k < 3; k++) begin
         chk(cpu_ready && !vpp_en, "R10 no retrigger while wr held", {cpu_ready, vpp_en}, 2);
         @(negedge clk); #1;
      end
      cpu_wr = 1'b0; mem_sel = 1'b0; ers_sel = 1'b0; skip_clear = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk(cpu_ready == 1'b1, "R11 ready after reset", cpu_ready, 1);
      chk(!vpp_en && !mem_we && !mem_erase, "R11 strobes off after reset",
          {vpp_en, mem_we, mem_erase}, 0);

      foreach (VECS[i]) run_vec(VECS[i]);

      // R1: select held without the write strobe
      @(negedge clk); mem_sel = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #1; chk(cpu_ready && !vpp_en, "R1 select without write", {cpu_ready, vpp_en}, 2);
         @(negedge clk);
      end
      // R9: read passes through with no stall
      cpu_rd = 1'b1; mem_rdata = 8'h96;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk(cpu_ready && mem_oe, "R9 read ready and oe", {cpu_ready, mem_oe}, 3);
         chk(cpu_rdata == mem_rdata, "R9 read data", cpu_rdata, mem_rdata);
         mem_rdata = mem_rdata + 8'h21;
         @(negedge clk);
      end
      cpu_rd = 1'b0; mem_sel = 1'b0;

      // R11: reset in the middle of a clearing pulse
      @(negedge clk);
      cpu_addr = 11'h0AA; cpu_wdata = 8'h3C; mem_sel = 1'b1; cpu_wr = 1'b1;
      repeat (3) @(negedge clk);
      #1; chk(vpp_en == 1'b1, "R11 pulse running before reset", vpp_en, 1);
      rst = 1'b1; cpu_wr = 1'b0; mem_sel = 1'b0;
      @(negedge clk); #1;
      chk(!vpp_en && !mem_we && cpu_ready, "R11 mid-sequence reset",
          {vpp_en, mem_we, cpu_ready}, 1);
      rst = 1'b0;
      @(negedge clk);

      // R2: a fresh write after reset still runs the full sequence
      run_vec('{1'b1, 1'b0, 1'b0, 11'h3C3, 8'hA5});

      done = 1'b1;
      summary();
      $finish;
   end
endmodule